// File: doc/BRIEF.md
# Data Access Break Comparator

This block sits beside a CPU data bus and watches every access. When an access matches a programmed break address, it raises a break request. The match can be narrowed by access size, by access direction and, if desired, by a masked comparison of the data on the bus. The address comparison adapts to the size of the access. A longword access ignores the two lowest address bits and a word access ignores the lowest bit. A single programmed address therefore catches any access whose span covers it.

Software sets up the channel through a small register write port. The port holds four registers: break address, control, break data and data mask. The control register carries the channel enable, the data-compare enable, a size selector and a direction selector. The data comparison uses the byte lanes that the access actually drives. Longwords use the whole bus and words use the low half. Bytes use bits 7..0 at an odd address and bits 15..8 at an even address. The result is a registered break pulse, one clock wide for each matching access.

`rst_n` is expected to be released synchronously to `clk` by the surrounding reset logic.

Top module: `dbrk_cmp`

## Requirements
- R1: After reset every register is zero, `brk_pulse` is low and the channel is disabled. No access causes a break until control bit 0 (enable) is written to 1.
- R2: For a longword access (`acc_size` = 11), only address bits 31..2 of the bus and of the break address are compared. Bits 1..0 are ignored.
- R3: For a word access (`acc_size` = 10), address bits 31..1 are compared and bit 0 is ignored.
- R4: For a byte access (`acc_size` = 01), all address bits 31..0 are compared. An `acc_size` of 00 never matches.
- R5: Control bits 3..2 select the size: 00 any size, 01 byte, 10 word, 11 longword. A nonzero value breaks only on accesses whose `acc_size` equals it.
- R6: Control bits 5..4 select the direction: 01 breaks on reads only (`acc_write` = 0), 10 breaks on writes only (`acc_write` = 1), and 00 or 11 break on either.
- R7: With control bit 1 (data compare) set, a break needs both the address condition and the data condition. A data-mask bit of 1 drops that bit from the compare. A mask bit of 0 requires the bus bit to equal the break data bit.
- R8: With the size selector at byte, an odd address compares data bits 7..0 under mask bits 7..0, and an even address compares bits 15..8 under mask bits 15..8. The other bits of the bus take no part.
- R9: With the size selector at word, data bits 15..0 are compared. For word and byte compares, bits 31..16 of the bus, of the break data register and of the mask register have no effect. With the selector at longword, all 32 bits are compared.
- R10: Data compare enabled together with size selector 00 is not a valid setup and never produces a break.
- R11: `brk_pulse` is registered. It is high in exactly the clock that follows a matching access with `acc_valid` high, and it never rises after a cycle with `acc_valid` low.
- R12: A write with `wr_en` high stores `wr_data` into the register chosen by `wr_sel`: 0 break address, 1 control, 2 break data, 3 data mask. The new value applies from the next cycle, so an access in the same cycle as a write is judged against the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 32 | Register write value |
| acc_valid | input | 1 | Bus access present this cycle |
| acc_addr | input | 32 | Access address |
| acc_data | input | 32 | Access data |
| acc_size | input | 2 | Access size: 01 byte, 10 word, 11 longword |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| brk_pulse | output | 1 | Registered break request |

## Verification
A register write and a bus access can land in the same clock. The bench provokes this by clearing the enable bit in the very cycle that a matching access is presented. The judgement is that the break still fires, because the access sees the old configuration, and that the next identical access stays quiet. A second overlap happens inside the comparator when the address and data conditions are evaluated together. Accesses are driven where one condition matches and the other misses, and each must produce no pulse.

// File: rtl/dbrk_pkg.sv
package dbrk_pkg;
  typedef enum logic [1:0] {
    SZ_ANY  = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_WORD = 2'b10,
    SZ_LONG = 2'b11
  } size_e;

  typedef enum logic [1:0] {
    RW_EITHER = 2'b00,
    RW_READ   = 2'b01,
    RW_WRITE  = 2'b10,
    RW_BOTH   = 2'b11
  } rwsel_e;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CTRL = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
  localparam logic [1:0] SEL_MASK = 2'd3;

  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_DCMP_BIT = 1;
  localparam int CTL_SZ_LSB   = 2;
  localparam int CTL_RW_LSB   = 4;
endpackage

// File: rtl/dbrk_regs.sv
module dbrk_regs
  import dbrk_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [31:0]   wr_data,
  output logic [AW-1:0] brk_addr,
  output logic [DW-1:0] brk_data,
  output logic [DW-1:0] brk_mask,
  output logic          ctl_en,
  output logic          ctl_dcmp,
  output logic [1:0]    ctl_size,
  output logic [1:0]    ctl_rw
);
  localparam int CTLW = 6;

  logic [AW-1:0]   addr_d;
  logic [DW-1:0]   data_d, mask_d;
  logic [CTLW-1:0] ctl_d, ctl_q;
  logic            addr_ce, data_ce, mask_ce, ctl_ce;

  always_comb begin
    addr_ce = wr_en && (wr_sel == SEL_ADDR);
    ctl_ce  = wr_en && (wr_sel == SEL_CTRL);
    data_ce = wr_en && (wr_sel == SEL_DATA);
    mask_ce = wr_en && (wr_sel == SEL_MASK);
    addr_d  = wr_data[AW-1:0];
    data_d  = wr_data[DW-1:0];
    mask_d  = wr_data[DW-1:0];
    ctl_d   = wr_data[CTLW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_addr <= '0;
      brk_data <= '0;
      brk_mask <= '0;
      ctl_q    <= '0;
    end else begin
      if (addr_ce) brk_addr <= addr_d;
      if (data_ce) brk_data <= data_d;
      if (mask_ce) brk_mask <= mask_d;
      if (ctl_ce)  ctl_q    <= ctl_d;
    end
  end

  assign ctl_en   = ctl_q[CTL_EN_BIT];
  assign ctl_dcmp = ctl_q[CTL_DCMP_BIT];
  assign ctl_size = ctl_q[CTL_SZ_LSB+1:CTL_SZ_LSB];
  assign ctl_rw   = ctl_q[CTL_RW_LSB+1:CTL_RW_LSB];
endmodule

// File: rtl/dbrk_addr_match.sv
module dbrk_addr_match
  import dbrk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] acc_addr,
  input  logic [1:0]    acc_size,
  input  logic          acc_write,
  input  logic [AW-1:0] brk_addr,
  input  logic [1:0]    ctl_size,
  input  logic [1:0]    ctl_rw,
  output logic          addr_hit
);
  logic [AW-1:0] keep;
  logic          size_legal, size_ok, rw_ok;

  always_comb begin
    size_legal = 1'b1;
    unique case (acc_size)
      SZ_LONG: keep = {AW{1'b1}} << 2;
      SZ_WORD: keep = {AW{1'b1}} << 1;
      SZ_BYTE: keep = {AW{1'b1}};
      default: begin
        keep       = '0;
        size_legal = 1'b0;
      end
    endcase
    size_ok = (ctl_size == SZ_ANY) || (ctl_size == acc_size);
    unique case (ctl_rw)
      RW_READ:  rw_ok = !acc_write;
      RW_WRITE: rw_ok = acc_write;
      default:  rw_ok = 1'b1;
    endcase
    addr_hit = size_legal && size_ok && rw_ok &&
               (((acc_addr ^ brk_addr) & keep) == '0);
  end
endmodule

// File: rtl/dbrk_data_match.sv
module dbrk_data_match
  import dbrk_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] acc_data,
  input  logic          addr_lsb,
  input  logic [DW-1:0] brk_data,
  input  logic [DW-1:0] brk_mask,
  input  logic          ctl_dcmp,
  input  logic [1:0]    ctl_size,
  output logic          data_ok
);
  localparam int BW = 8;
  localparam logic [DW-1:0] LANE_B0 = {{(DW-BW){1'b0}}, {BW{1'b1}}};
  localparam logic [DW-1:0] LANE_B1 = LANE_B0 << BW;
  localparam logic [DW-1:0] LANE_W  = LANE_B0 | LANE_B1;
  localparam logic [DW-1:0] LANE_L  = {DW{1'b1}};

  logic [DW-1:0] lane;
  logic          cfg_ok;

  always_comb begin
    cfg_ok = 1'b1;
    unique case (ctl_size)
      SZ_BYTE: lane = addr_lsb ? LANE_B0 : LANE_B1;
      SZ_WORD: lane = LANE_W;
      SZ_LONG: lane = LANE_L;
      default: begin
        lane   = '0;
        cfg_ok = 1'b0;
      end
    endcase
    data_ok = !ctl_dcmp ||
              (cfg_ok && (((acc_data ^ brk_data) & ~brk_mask & lane) == '0));
  end
endmodule

// File: rtl/dbrk_cmp.sv
module dbrk_cmp
  import dbrk_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [31:0]   wr_data,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] acc_data,
  input  logic [1:0]    acc_size,
  input  logic          acc_write,
  output logic          brk_pulse
);
  logic [AW-1:0] brk_addr;
  logic [DW-1:0] brk_data, brk_mask;
  logic          ctl_en, ctl_dcmp;
  logic [1:0]    ctl_size, ctl_rw;
  logic          addr_hit, data_ok;
  logic          pulse_d, pulse_q;

  dbrk_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .brk_addr(brk_addr), .brk_data(brk_data), .brk_mask(brk_mask),
    .ctl_en(ctl_en), .ctl_dcmp(ctl_dcmp), .ctl_size(ctl_size), .ctl_rw(ctl_rw)
  );

  dbrk_addr_match #(.AW(AW)) u_addr (
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_write(acc_write),
    .brk_addr(brk_addr), .ctl_size(ctl_size), .ctl_rw(ctl_rw),
    .addr_hit(addr_hit)
  );

  dbrk_data_match #(.DW(DW)) u_data (
    .acc_data(acc_data), .addr_lsb(acc_addr[0]),
    .brk_data(brk_data), .brk_mask(brk_mask),
    .ctl_dcmp(ctl_dcmp), .ctl_size(ctl_size),
    .data_ok(data_ok)
  );

  always_comb begin
    pulse_d = ctl_en && acc_valid && addr_hit && data_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign brk_pulse = pulse_q;
endmodule

// File: rtl/dbrk_cmp_chk.sv
module dbrk_cmp_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic [AW-1:0] acc_addr,
  input logic [1:0]    acc_size,
  input logic          acc_write,
  input logic [AW-1:0] brk_addr,
  input logic          ctl_en,
  input logic          ctl_dcmp,
  input logic [1:0]    ctl_size,
  input logic [1:0]    ctl_rw,
  input logic          brk_pulse
);
  a_r11_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |-> $past(acc_valid));

  a_r1_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |-> $past(ctl_en));

  a_r2_upper_addr: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |-> ($past(acc_addr[AW-1:2]) == $past(brk_addr[AW-1:2])));

  a_r5_size_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_pulse && ($past(ctl_size) != 2'b00)) |-> ($past(acc_size) == $past(ctl_size)));

  a_r10_dcmp_needs_size: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_pulse && $past(ctl_dcmp)) |-> ($past(ctl_size) != 2'b00));

  a_r6_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_pulse && ($past(ctl_rw) == 2'b01)) |-> !$past(acc_write));
endmodule

bind dbrk_cmp dbrk_cmp_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_size(acc_size),
  .acc_write(acc_write), .brk_addr(brk_addr), .ctl_en(ctl_en),
  .ctl_dcmp(ctl_dcmp), .ctl_size(ctl_size), .ctl_rw(ctl_rw),
  .brk_pulse(brk_pulse)
);

// File: tb/tb_dbrk_cmp.sv
`timescale 1ns/1ps
module tb_dbrk_cmp;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic        acc_valid;
  logic [31:0] acc_addr, acc_data;
  logic [1:0]  acc_size;
  logic        acc_write;
  logic        brk_pulse;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  localparam logic [1:0] B = 2'b01, W = 2'b10, L = 2'b11;

  always #2 clk = ~clk;

  dbrk_cmp dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_data(acc_data),
    .acc_size(acc_size), .acc_write(acc_write), .brk_pulse(brk_pulse)
  );

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: brk_pulse=%0b expected=%0b", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctl(input bit en, input bit dc,
                                      input logic [1:0] sz, input logic [1:0] rw);
    return {26'd0, rw, sz, dc, en};
  endfunction

  task automatic wreg(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // One access, the pulse judged one clock later, then the pulse must drop (R11)
  task automatic access(input logic [31:0] a, input logic [31:0] d,
                        input logic [1:0] sz, input bit wr, input logic exp,
                        input string req);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_data = d; acc_size = sz; acc_write = wr;
    @(negedge clk);
    acc_valid = 1'b0;
    check(brk_pulse, exp, req);
    @(negedge clk);
    if (exp) check(brk_pulse, 1'b0, "R11 single cycle");
  endtask

  task automatic t_reset;
    check(brk_pulse, 1'b0, "R1 reset value");
    access(32'h0, 32'h0, B, 1'b0, 1'b0, "R1 disabled after reset");
  endtask

  task automatic t_addr_any;
    wreg(2'd0, 32'h0000_1003);
    wreg(2'd1, ctl(1, 0, 2'b00, 2'b00));
    access(32'h0000_1000, 0, L, 0, 1'b1, "R2 long covers 1003");
    access(32'h0000_1004, 0, L, 0, 1'b0, "R2 long next word");
    access(32'h0000_1002, 0, W, 0, 1'b1, "R3 word covers 1003");
    access(32'h0000_1000, 0, W, 0, 1'b0, "R3 word other half");
    access(32'h0000_1003, 0, B, 0, 1'b1, "R4 byte exact");
    access(32'h0000_1002, 0, B, 0, 1'b0, "R4 byte neighbour");
    access(32'h0000_1003, 0, 2'b00, 0, 1'b0, "R4 size 00 never");
    access(32'h8000_1003, 0, B, 0, 1'b0, "R4 high bit differs");
  endtask

  task automatic t_size_sel;
    wreg(2'd1, ctl(1, 0, B, 2'b00));
    access(32'h0000_1002, 0, W, 0, 1'b0, "R5 byte sel rejects word");
    access(32'h0000_1003, 0, B, 0, 1'b1, "R5 byte sel takes byte");
    wreg(2'd1, ctl(1, 0, L, 2'b00));
    access(32'h0000_1003, 0, B, 0, 1'b0, "R5 long sel rejects byte");
    access(32'h0000_1000, 0, L, 0, 1'b1, "R5 long sel takes long");
  endtask

  task automatic t_rw;
    wreg(2'd1, ctl(1, 0, 2'b00, 2'b01));
    access(32'h0000_1003, 0, B, 1, 1'b0, "R6 read only rejects write");
    access(32'h0000_1003, 0, B, 0, 1'b1, "R6 read only takes read");
    wreg(2'd1, ctl(1, 0, 2'b00, 2'b10));
    access(32'h0000_1003, 0, B, 0, 1'b0, "R6 write only rejects read");
    access(32'h0000_1003, 0, B, 1, 1'b1, "R6 write only takes write");
  endtask

  task automatic t_data;
    // odd byte lane
    wreg(2'd2, 32'hAABB_CC5A);
    wreg(2'd3, 32'h0);
    wreg(2'd1, ctl(1, 1, B, 2'b00));
    access(32'h0000_1003, 32'h1234_565A, B, 0, 1'b1, "R8 odd lane match");
    access(32'h0000_1003, 32'hAABB_CC5B, B, 0, 1'b0, "R7 data miss");
    wreg(2'd3, 32'h0000_0001);
    access(32'h0000_1003, 32'hAABB_CC5B, B, 0, 1'b1, "R7 masked bit ignored");
    // even byte lane
    wreg(2'd0, 32'h0000_1002);
    wreg(2'd2, 32'h0000_3C00);
    wreg(2'd3, 32'h0);
    access(32'h0000_1002, 32'hFFFF_3C77, B, 0, 1'b1, "R8 even lane match");
    access(32'h0000_1002, 32'h0000_3D00, B, 0, 1'b0, "R8 even lane miss");
    // word
    wreg(2'd2, 32'hDEAD_1234);
    wreg(2'd1, ctl(1, 1, W, 2'b00));
    access(32'h0000_1002, 32'h0000_1234, W, 0, 1'b1, "R9 word upper ignored");
    access(32'h0000_1002, 32'h0000_1235, W, 0, 1'b0, "R9 word low miss");
    // longword
    wreg(2'd0, 32'h0000_1000);
    wreg(2'd2, 32'hDEAD_BEEF);
    wreg(2'd1, ctl(1, 1, L, 2'b00));
    access(32'h0000_1000, 32'hDEAD_BEEF, L, 0, 1'b1, "R9 long full match");
    access(32'h0000_1000, 32'h1EAD_BEEF, L, 0, 1'b0, "R9 long top bit miss");
    access(32'h0000_1004, 32'hDEAD_BEEF, L, 0, 1'b0, "R7 data ok addr miss");
    // data compare with any size
    wreg(2'd1, ctl(1, 1, 2'b00, 2'b00));
    access(32'h0000_1000, 32'hDEAD_BEEF, L, 0, 1'b0, "R10 dcmp with any size");
  endtask

  task automatic t_valid_low;
    wreg(2'd1, ctl(1, 0, 2'b00, 2'b00));
    @(negedge clk);
    acc_valid = 1'b0; acc_addr = 32'h0000_1000; acc_size = L; acc_write = 0;
    @(negedge clk);
    check(brk_pulse, 1'b0, "R11 valid low no break");
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd1; wr_data = 32'h0;
    acc_valid = 1'b1; acc_addr = 32'h0000_1000; acc_size = L; acc_write = 0;
    @(negedge clk);
    wr_en = 1'b0; acc_valid = 1'b0;
    check(brk_pulse, 1'b1, "R12 old config in write cycle");
    access(32'h0000_1000, 0, L, 0, 1'b0, "R12 disable applied next");
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 0; wr_sel = 0; wr_data = 0;
    acc_valid = 0; acc_addr = 0; acc_data = 0; acc_size = 0; acc_write = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_addr_any();
    t_size_sel();
    t_rw();
    t_data();
    t_valid_low();
    t_same_cycle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: done=0 expected=1");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule